// File: doc/BRIEF.md
# Power Rail Fault Supervisor

This block watches a group of converter output rails, along with the converter's input voltage and two temperature sensors. It works only from digitised readings and decides which rails are allowed to run. Each rail gets a shutdown request. Shared status goes out on three paths: an active-low fail line, an active-low system-reset line, and a red/green indicator. A six-bit fault cause word is also provided so a status register can read it.

All decisions are made on a sample tick that is derived from the clock by a parameterised divider. The following are all counted in ticks:

- input qualification
- the start-up hold
- soft-start blanking
- the long retry period, the short retry period and the blink half-period

Two recovery policies are available:

- **Normal policy.** Any rail fault turns every rail off, waits the long retry period, and restarts.
- **Isolate policy.** Selected by an input. Only the failing rail is turned off, and it comes back after the short retry period. A fault on rail 0, the main rail, also turns off the rails marked as derived from it.

Top module: `rail_fault_supervisor`

## Requirements
- R1: While reset is high and immediately after it, all shutdown bits are 1. `fail_n` and `sysrst_n` are 0, `led_red` is 1, `led_green` is 0 and `flags_o` is 0.
- R2: Once the input reading is inside [VIN_UV, VIN_OV], the block holds every rail off with both lines low and steady red for START_TICKS samples. It then releases both lines and lets each enabled rail run.
- R3: QUAL_TICKS consecutive out-of-range input samples turn everything off and return the block to the start-up hold. They also set flags bit 4, which clears when start-up completes. A shorter out-of-range run has no effect.
- R4: Once a rail's soft-start has ended, a voltage above its OV limit or below its UV limit turns all rails off for RETRY_TICKS samples, with `fail_n` low. The block then restarts, and the cycle repeats while the fault persists.
- R5: The fast current limit (current above FAST_LIM) is ignored until a rail has run for SS_TICKS samples since it was last enabled. After that it trips on the first sample.
- R6: A filtered current, updated per sample as f += (i − f) >>> FILT_SHIFT and reset while the rail is off, trips the rail when f exceeds SLOW_LIM.
- R7: Either temperature at or above OT_TRIP turns all rails off and sets flags bit 5. Rails resume only when both temperatures are at or below OT_TRIP − OT_HYST.
- R8: With `isolate_mode` high, a fault on a non-main rail turns off only that rail, for ISO_TICKS samples, after which it soft-starts again.
- R9: In isolate mode, a fault on rail 0 also turns off every rail whose AUX_MASK bit is set, until rail 0 returns.
- R10: Indicator encoding, with blink toggling every BLINK_TICKS samples:
  - Start-up and input-off give steady red with both lines low.
  - During a retry, an over-temperature hold or any isolated rail, red blinks, `fail_n` is 0 and `sysrst_n` is 1.
  - Otherwise green is steady when every rail is enabled and blinks if not.
- R11: Flags bits 0 to 3 record OV, UV, fast OC and slow OC. They are sticky until a sample in the running state with no rail fault and no isolated rail.
- R12: State changes only on sample ticks, one every TICK_DIV clocks. Outputs are registered one clock after the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vin_smp | input | W | Input voltage reading |
| rail_v | input | N*W | Rail voltage readings, rail k at [k*W +: W] |
| rail_i | input | N*W | Rail current readings, same packing |
| temp_a | input | TW | First temperature reading |
| temp_b | input | TW | Second temperature reading |
| rail_en | input | N | Per-rail enable request |
| isolate_mode | input | 1 | Selects per-rail isolation and short retry |
| shutdown_o | output | N | Per-rail shutdown request (1 = off) |
| fail_n | output | 1 | Fail line, active low |
| sysrst_n | output | 1 | System reset line, active low |
| led_red | output | 1 | Red indicator drive |
| led_green | output | 1 | Green indicator drive |
| flags_o | output | 6 | {hot, input, slow OC, fast OC, UV, OV} |

## Verification
The bench first drives a fast over-current onto a freshly enabled rail. A design that forgot the soft-start blanking would trip on the first sample, and one that blanked forever would never trip.

It holds an over-voltage across several retry periods, which exposes a timer that miscounts or never restarts the rails. It sets the temperature just above the recovery point, which catches missing hysteresis. It sends an input glitch one sample shorter than the qualification window, which shows an unqualified input check.

In isolate mode, it faults a secondary rail and then the main rail. A design that shut everything down, or that left the derived rails running, shows up as a wrong shutdown pattern.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_START,
    ST_RUN,
    ST_RETRY,
    ST_HOT
  } sup_state_e;

  // Cause word bit positions
  localparam int FLAG_OV  = 0;
  localparam int FLAG_UV  = 1;
  localparam int FLAG_FOC = 2;
  localparam int FLAG_SOC = 3;
  localparam int FLAG_VIN = 4;
  localparam int FLAG_HOT = 5;
  localparam int FLAG_W   = 6;

  typedef struct packed {
    logic soc;
    logic foc;
    logic uv;
    logic ov;
  } rail_flt_t;

endpackage

// File: rtl/rfs_tick_gen.sv
module rfs_tick_gen #(
  parameter int TICK_DIV    = 10000,
  parameter int BLINK_TICKS = 1250
) (
  input  logic clk,
  input  logic rst,
  output logic tick,
  output logic blink
);
  localparam int DW = $clog2(TICK_DIV + 1);
  localparam int BW = $clog2(BLINK_TICKS + 1);

  logic [DW-1:0] div_q;
  logic [BW-1:0] bl_q;

  assign tick = (div_q == DW'(TICK_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      bl_q  <= '0;
      blink <= 1'b0;
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) begin
        if (bl_q == BW'(BLINK_TICKS - 1)) begin
          bl_q  <= '0;
          blink <= ~blink;
        end else begin
          bl_q <= bl_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rfs_rail_mon.sv
module rfs_rail_mon
  import rfs_pkg::*;
#(
  parameter int W          = 12,
  parameter int SS_TICKS   = 25,
  parameter int ISO_TICKS  = 1000,
  parameter int FILT_SHIFT = 2,
  parameter logic [W-1:0] OV_LIM   = W'(3200),
  parameter logic [W-1:0] UV_LIM   = W'(2800),
  parameter logic [W-1:0] FAST_LIM = W'(3000),
  parameter logic [W-1:0] SLOW_LIM = W'(2000)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         allowed,
  input  logic         run,
  input  logic         iso_mode,
  input  logic [W-1:0] v_smp,
  input  logic [W-1:0] i_smp,
  output rail_flt_t    flt,
  output logic         iso_off
);
  localparam int SW = $clog2(SS_TICKS + 1);
  localparam int IW = $clog2(ISO_TICKS + 1);

  logic [SW-1:0]       ss_q;
  logic [IW-1:0]       iso_q;
  logic [W-1:0]        filt_q;
  logic                ss_done, armed, any_flt;
  logic signed [W+1:0] diff, step, filt_sum;

  assign ss_done  = (ss_q == SW'(SS_TICKS));
  assign armed    = allowed && ss_done;
  assign diff     = $signed({2'b00, i_smp}) - $signed({2'b00, filt_q});
  assign step     = diff >>> FILT_SHIFT;
  assign filt_sum = $signed({2'b00, filt_q}) + step;

  always_comb begin
    flt.ov  = armed && (v_smp > OV_LIM);
    flt.uv  = armed && (v_smp < UV_LIM);
    flt.foc = armed && (i_smp > FAST_LIM);
    flt.soc = allowed && (filt_q > SLOW_LIM);
  end

  assign any_flt = |flt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ss_q    <= '0;
      filt_q  <= '0;
      iso_q   <= '0;
      iso_off <= 1'b0;
    end else if (tick) begin
      if (!allowed) begin
        ss_q   <= '0;
        filt_q <= '0;
      end else begin
        if (!ss_done) ss_q <= ss_q + 1'b1;
        filt_q <= filt_sum[W-1:0];
      end
      if (!run) begin
        iso_off <= 1'b0;
        iso_q   <= '0;
      end else if (iso_off) begin
        if (iso_q == IW'(ISO_TICKS - 1)) begin
          iso_off <= 1'b0;
          iso_q   <= '0;
        end else begin
          iso_q <= iso_q + 1'b1;
        end
      end else if (iso_mode && any_flt) begin
        iso_off <= 1'b1;
        iso_q   <= '0;
      end
    end
  end
endmodule

// File: rtl/rfs_seq.sv
module rfs_seq
  import rfs_pkg::*;
#(
  parameter int VW          = 12,
  parameter int TW          = 8,
  parameter int VIN_UV      = 1800,
  parameter int VIN_OV      = 3500,
  parameter int OT_TRIP     = 98,
  parameter int OT_HYST     = 20,
  parameter int QUAL_TICKS  = 5,
  parameter int START_TICKS = 500,
  parameter int RETRY_TICKS = 5000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [VW-1:0] vin_smp,
  input  logic [TW-1:0] temp_a,
  input  logic [TW-1:0] temp_b,
  input  logic          rail_trip,
  output sup_state_e    state,
  output logic          vin_flag
);
  localparam int TMAX = (START_TICKS > RETRY_TICKS) ? START_TICKS : RETRY_TICKS;
  localparam int CW   = $clog2(TMAX + 1);
  localparam int QW   = $clog2(QUAL_TICKS + 1);
  localparam int COOL = OT_TRIP - OT_HYST;

  logic [CW-1:0] tmr_q;
  logic [QW-1:0] bad_q, bad_nx;
  logic          vin_ok, in_trip, hot, cool;

  assign vin_ok  = (vin_smp >= VW'(VIN_UV)) && (vin_smp <= VW'(VIN_OV));
  assign bad_nx  = vin_ok ? '0 :
                   (bad_q == QW'(QUAL_TICKS)) ? bad_q : bad_q + 1'b1;
  assign in_trip = (bad_nx == QW'(QUAL_TICKS));
  assign hot     = (temp_a >= TW'(OT_TRIP)) || (temp_b >= TW'(OT_TRIP));
  assign cool    = (temp_a <= TW'(COOL)) && (temp_b <= TW'(COOL));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_OFF;
      tmr_q    <= '0;
      bad_q    <= '0;
      vin_flag <= 1'b0;
    end else if (tick) begin
      bad_q <= bad_nx;
      if (state == ST_OFF) begin
        if (vin_ok) begin
          state <= ST_START;
          tmr_q <= '0;
        end
      end else if (in_trip) begin
        state    <= ST_OFF;
        vin_flag <= 1'b1;
      end else begin
        unique case (state)
          ST_START: begin
            if (tmr_q == CW'(START_TICKS - 1)) begin
              state    <= ST_RUN;
              tmr_q    <= '0;
              vin_flag <= 1'b0;
            end else begin
              tmr_q <= tmr_q + 1'b1;
            end
          end
          ST_RUN: begin
            if (hot) begin
              state <= ST_HOT;
            end else if (rail_trip) begin
              state <= ST_RETRY;
              tmr_q <= '0;
            end
          end
          ST_RETRY: begin
            if (hot) begin
              state <= ST_HOT;
            end else if (tmr_q == CW'(RETRY_TICKS - 1)) begin
              state <= ST_RUN;
              tmr_q <= '0;
            end else begin
              tmr_q <= tmr_q + 1'b1;
            end
          end
          ST_HOT: begin
            if (cool) state <= ST_RUN;
          end
          default: state <= ST_OFF;
        endcase
      end
    end
  end
endmodule

// File: rtl/rail_fault_supervisor.sv
module rail_fault_supervisor
  import rfs_pkg::*;
#(
  parameter int N           = 4,
  parameter int W           = 12,
  parameter int TW          = 8,
  parameter int TICK_DIV    = 10000,
  parameter int BLINK_TICKS = 1250,
  parameter int QUAL_TICKS  = 5,
  parameter int START_TICKS = 500,
  parameter int RETRY_TICKS = 5000,
  parameter int ISO_TICKS   = 1000,
  parameter int SS_TICKS    = 25,
  parameter int FILT_SHIFT  = 2,
  parameter int VIN_UV      = 1800,
  parameter int VIN_OV      = 3500,
  parameter int OT_TRIP     = 98,
  parameter int OT_HYST     = 20,
  parameter logic [N-1:0]   AUX_MASK = {{(N-1){1'b1}}, 1'b0},
  parameter logic [N*W-1:0] OV_LIM   = {N{W'(3200)}},
  parameter logic [N*W-1:0] UV_LIM   = {N{W'(2800)}},
  parameter logic [N*W-1:0] FAST_LIM = {N{W'(3000)}},
  parameter logic [N*W-1:0] SLOW_LIM = {N{W'(2000)}}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [W-1:0]      vin_smp,
  input  logic [N*W-1:0]    rail_v,
  input  logic [N*W-1:0]    rail_i,
  input  logic [TW-1:0]     temp_a,
  input  logic [TW-1:0]     temp_b,
  input  logic [N-1:0]      rail_en,
  input  logic              isolate_mode,
  output logic [N-1:0]      shutdown_o,
  output logic              fail_n,
  output logic              sysrst_n,
  output logic              led_red,
  output logic              led_green,
  output logic [FLAG_W-1:0] flags_o
);
  logic       tick, blink;
  sup_state_e state;
  logic       vin_flag;
  logic       run;
  logic [N-1:0] allowed, iso_off, rail_bad;
  rail_flt_t    flt [N];
  logic [3:0]   new_bits, rail_flags_q;
  logic         any_iso, any_bad, rail_trip, clr_flags;

  rfs_tick_gen #(
    .TICK_DIV(TICK_DIV), .BLINK_TICKS(BLINK_TICKS)
  ) tick_i (
    .clk(clk), .rst(rst), .tick(tick), .blink(blink)
  );

  assign run = (state == ST_RUN);

  for (genvar k = 0; k < N; k++) begin : g_rail
    if (k == 0) begin : g_main
      assign allowed[k] = run && rail_en[k] && !iso_off[k];
    end else begin : g_sub
      assign allowed[k] = run && rail_en[k] && !iso_off[k] &&
                          !(AUX_MASK[k] && iso_off[0]);
    end

    rfs_rail_mon #(
      .W(W), .SS_TICKS(SS_TICKS), .ISO_TICKS(ISO_TICKS), .FILT_SHIFT(FILT_SHIFT),
      .OV_LIM(OV_LIM[k*W +: W]), .UV_LIM(UV_LIM[k*W +: W]),
      .FAST_LIM(FAST_LIM[k*W +: W]), .SLOW_LIM(SLOW_LIM[k*W +: W])
    ) mon_i (
      .clk(clk), .rst(rst), .tick(tick),
      .allowed(allowed[k]), .run(run), .iso_mode(isolate_mode),
      .v_smp(rail_v[k*W +: W]), .i_smp(rail_i[k*W +: W]),
      .flt(flt[k]), .iso_off(iso_off[k])
    );

    assign rail_bad[k] = |flt[k];
  end

  always_comb begin
    new_bits = '0;
    for (int k = 0; k < N; k++) new_bits |= flt[k];
  end

  assign any_iso   = |iso_off;
  assign any_bad   = |rail_bad;
  assign rail_trip = any_bad && !isolate_mode;
  assign clr_flags = run && !any_iso && !any_bad;

  rfs_seq #(
    .VW(W), .TW(TW), .VIN_UV(VIN_UV), .VIN_OV(VIN_OV),
    .OT_TRIP(OT_TRIP), .OT_HYST(OT_HYST), .QUAL_TICKS(QUAL_TICKS),
    .START_TICKS(START_TICKS), .RETRY_TICKS(RETRY_TICKS)
  ) seq_i (
    .clk(clk), .rst(rst), .tick(tick), .vin_smp(vin_smp),
    .temp_a(temp_a), .temp_b(temp_b), .rail_trip(rail_trip),
    .state(state), .vin_flag(vin_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rail_flags_q <= '0;
    end else if (tick) begin
      rail_flags_q <= (clr_flags ? 4'b0 : rail_flags_q) | new_bits;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shutdown_o <= '1;
      fail_n     <= 1'b0;
      sysrst_n   <= 1'b0;
      led_red    <= 1'b1;
      led_green  <= 1'b0;
      flags_o    <= '0;
    end else begin
      shutdown_o <= ~allowed;
      flags_o    <= {state == ST_HOT, vin_flag, rail_flags_q};
      if (state == ST_OFF || state == ST_START) begin
        led_red   <= 1'b1;
        led_green <= 1'b0;
        fail_n    <= 1'b0;
        sysrst_n  <= 1'b0;
      end else if (state == ST_RETRY || state == ST_HOT || any_iso) begin
        led_red   <= blink;
        led_green <= 1'b0;
        fail_n    <= 1'b0;
        sysrst_n  <= 1'b1;
      end else begin
        led_red   <= 1'b0;
        led_green <= (&rail_en) ? 1'b1 : blink;
        fail_n    <= 1'b1;
        sysrst_n  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rfs_chk.sv
module rfs_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         tick,
  input logic [N-1:0] shutdown_o,
  input logic         fail_n,
  input logic         sysrst_n,
  input logic         led_red,
  input logic         led_green,
  input logic [5:0]   flags_o
);
  // R2/R3: while the reset line is held, no rail may run
  a_r3_hold_all_off: assert property (@(posedge clk) disable iff (rst)
    !sysrst_n |-> (&shutdown_o));

  // R10: the reset line is never low while the fail line is released
  a_r10_rst_implies_fail: assert property (@(posedge clk) disable iff (rst)
    !sysrst_n |-> !fail_n);

  // R10: indicator colours are exclusive
  a_r10_led_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(led_red && led_green));

  // R7: over-temperature implies every rail off
  a_r7_hot_all_off: assert property (@(posedge clk) disable iff (rst)
    flags_o[5] |-> (&shutdown_o));

  // R12: the reset line moves only two clocks after a sample tick
  a_r12_tick_aligned: assert property (@(posedge clk) disable iff (rst)
    !$stable(sysrst_n) |-> $past(tick, 2));
endmodule

bind rail_fault_supervisor rfs_chk #(.N(N)) chk_i (
  .clk(clk), .rst(rst), .tick(tick), .shutdown_o(shutdown_o),
  .fail_n(fail_n), .sysrst_n(sysrst_n), .led_red(led_red),
  .led_green(led_green), .flags_o(flags_o)
);

// File: tb/rail_fault_supervisor_tb_top.sv
`timescale 1ns/1ps
module rail_fault_supervisor_tb_top;
  localparam int N = 4, W = 12, TW = 8;
  localparam int TD = 3, BL = 3, QL = 3, ST = 8, RT = 12, IS = 5, SS = 4, FS = 2;
  localparam logic [3:0] AUXM = 4'b1010;

  logic clk = 0, rst = 1;
  logic [W-1:0] vin = 0;
  logic [W-1:0] rv [N];
  logic [W-1:0] ri [N];
  logic [TW-1:0] ta = 40, tb = 40;
  logic [N-1:0] ren = 4'hF;
  logic iso = 0;
  logic [N-1:0] shutdown_o;
  logic fail_n, sysrst_n, led_red, led_green;
  logic [5:0] flags_o;

  int n_chk = 0, n_err = 0;
  string req_tag = "R1";
  bit chk_on = 0;

  always #10 clk = ~clk;

  rail_fault_supervisor #(
    .N(N), .W(W), .TW(TW), .TICK_DIV(TD), .BLINK_TICKS(BL), .QUAL_TICKS(QL),
    .START_TICKS(ST), .RETRY_TICKS(RT), .ISO_TICKS(IS), .SS_TICKS(SS),
    .FILT_SHIFT(FS), .AUX_MASK(AUXM)
  ) dut_i (
    .clk(clk), .rst(rst), .vin_smp(vin),
    .rail_v({rv[3], rv[2], rv[1], rv[0]}), .rail_i({ri[3], ri[2], ri[1], ri[0]}),
    .temp_a(ta), .temp_b(tb), .rail_en(ren), .isolate_mode(iso),
    .shutdown_o(shutdown_o), .fail_n(fail_n), .sysrst_n(sysrst_n),
    .led_red(led_red), .led_green(led_green), .flags_o(flags_o)
  );

  // Behavioural reference model
  int m_div, m_bl, m_st, m_tmr, m_bad;
  bit m_ph, m_vinf;
  bit [3:0] m_rf;
  int m_ss [N];
  int m_filt [N];
  int m_isot [N];
  bit m_iso [N];
  logic [N-1:0] e_sd;
  logic e_fail, e_rst, e_red, e_grn;
  logic [5:0] e_fl;

  always @(posedge clk) begin
    bit al [N];
    bit [3:0] fl [N];
    bit any_iso, tk, anyf, armed, clr, ok, hot, cool;
    bit [3:0] nb;
    if (rst) begin
      m_div = 0; m_bl = 0; m_ph = 0; m_st = 0; m_tmr = 0; m_bad = 0;
      m_vinf = 0; m_rf = 0;
      for (int k = 0; k < N; k++) begin
        m_ss[k] = 0; m_filt[k] = 0; m_isot[k] = 0; m_iso[k] = 0;
      end
      e_sd = '1; e_fail = 0; e_rst = 0; e_red = 1; e_grn = 0; e_fl = 0;
    end else begin
      any_iso = 0;
      for (int k = 0; k < N; k++) begin
        al[k] = (m_st == 2) && ren[k] && !m_iso[k] && !(k != 0 && AUXM[k] && m_iso[0]);
        any_iso |= m_iso[k];
        e_sd[k] = !al[k];
      end
      if (m_st <= 1) begin
        e_red = 1; e_grn = 0; e_fail = 0; e_rst = 0;
      end else if (m_st >= 3 || any_iso) begin
        e_red = m_ph; e_grn = 0; e_fail = 0; e_rst = 1;
      end else begin
        e_red = 0; e_grn = (&ren) ? 1'b1 : m_ph; e_fail = 1; e_rst = 1;
      end
      e_fl = {m_st == 4, m_vinf, m_rf};
      tk = (m_div == TD - 1);
      if (tk) begin
        nb = 0; anyf = 0;
        for (int k = 0; k < N; k++) begin
          armed = al[k] && (m_ss[k] == SS);
          fl[k] = {al[k] && m_filt[k] > 2000, armed && ri[k] > 3000,
                   armed && rv[k] < 2800, armed && rv[k] > 3200};
          nb |= fl[k];
          anyf |= (fl[k] != 0);
        end
        for (int k = 0; k < N; k++) begin
          if (!al[k]) begin
            m_ss[k] = 0; m_filt[k] = 0;
          end else begin
            if (m_ss[k] < SS) m_ss[k]++;
            m_filt[k] = m_filt[k] + ((int'(ri[k]) - m_filt[k]) >>> FS);
          end
          if (m_st != 2) begin
            m_iso[k] = 0; m_isot[k] = 0;
          end else if (m_iso[k]) begin
            if (m_isot[k] == IS - 1) begin m_iso[k] = 0; m_isot[k] = 0; end
            else m_isot[k]++;
          end else if (iso && fl[k] != 0) begin
            m_iso[k] = 1; m_isot[k] = 0;
          end
        end
        clr = (m_st == 2) && !any_iso && !anyf;
        m_rf = (clr ? 4'b0 : m_rf) | nb;
        ok = (vin >= 1800) && (vin <= 3500);
        m_bad = ok ? 0 : (m_bad == QL ? QL : m_bad + 1);
        hot = (ta >= 98) || (tb >= 98);
        cool = (ta <= 78) && (tb <= 78);
        if (m_st == 0) begin
          if (ok) begin m_st = 1; m_tmr = 0; end
        end else if (m_bad == QL) begin
          m_st = 0; m_vinf = 1;
        end else if (m_st == 1) begin
          if (m_tmr == ST - 1) begin m_st = 2; m_tmr = 0; m_vinf = 0; end
          else m_tmr++;
        end else if (m_st == 2) begin
          if (hot) m_st = 4;
          else if (anyf && !iso) begin m_st = 3; m_tmr = 0; end
        end else if (m_st == 3) begin
          if (hot) m_st = 4;
          else if (m_tmr == RT - 1) begin m_st = 2; m_tmr = 0; end
          else m_tmr++;
        end else if (m_st == 4) begin
          if (cool) m_st = 2;
        end
        if (m_bl == BL - 1) begin m_bl = 0; m_ph = !m_ph; end
        else m_bl++;
      end
      m_div = tk ? 0 : m_div + 1;
    end
  end

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (chk_on) begin
      n_chk++;
      if ({shutdown_o, fail_n, sysrst_n, led_red, led_green, flags_o} !==
          {e_sd, e_fail, e_rst, e_red, e_grn, e_fl}) begin
        n_err++;
        $display("FAIL %s: {sd,fail,rst,red,grn,flags} got %b expected %b", req_tag,
                 {shutdown_o, fail_n, sysrst_n, led_red, led_green, flags_o},
                 {e_sd, e_fail, e_rst, e_red, e_grn, e_fl});
      end
    end
  end

  task automatic chk(input string r, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", r, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n * TD) @(negedge clk);
  endtask

  bit done = 0;
  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < N; k++) begin rv[k] = 3000; ri[k] = 1000; end
    repeat (2) @(negedge clk);
    chk_on = 1;
    repeat (3) @(negedge clk);
    req_tag = "R1";
    chk("R1 shutdown", 16'(shutdown_o), 16'hF);
    chk("R1 lines", 16'({fail_n, sysrst_n, led_red, led_green}), 16'b0010);
    rst = 0;
    ticks(5);
    req_tag = "R3";
    chk("R3 off with bad input", 16'(sysrst_n), 16'h0);
    req_tag = "R2";
    vin = 2800;
    ticks(12);
    chk("R2 released", 16'({sysrst_n, fail_n}), 16'b11);
    chk("R2 rails on", 16'(shutdown_o), 16'h0);
    chk("R10 steady green", 16'({led_red, led_green}), 16'b01);
    req_tag = "R10";
    ren = 4'b0111;
    ticks(10);
    ren = 4'hF;
    req_tag = "R12";
    ticks(6);
    req_tag = "R4";
    rv[2] = 3400;
    ticks(3);
    chk("R4 fail low", 16'(fail_n), 16'h0);
    chk("R4 all off", 16'(shutdown_o), 16'hF);
    ticks(37);
    rv[2] = 3000;
    ticks(20);
    chk("R4 recovered", 16'(fail_n), 16'h1);
    req_tag = "R11";
    rv[1] = 2700;
    ticks(2);
    chk("R11 uv flag", 16'(flags_o[1]), 16'h1);
    ticks(6);
    rv[1] = 3000;
    ticks(20);
    req_tag = "R5";
    ren[2] = 0;
    ticks(2);
    ri[2] = 3100;
    ren[2] = 1;
    ticks(2);
    chk("R5 blanked", 16'(shutdown_o[2]), 16'h0);
    ticks(6);
    ri[2] = 1000;
    ticks(20);
    req_tag = "R6";
    ri[1] = 2500;
    ticks(30);
    ri[1] = 1000;
    ticks(20);
    req_tag = "R7";
    ta = 98;
    ticks(5);
    chk("R7 hot flag", 16'(flags_o[5]), 16'h1);
    chk("R7 all off", 16'(shutdown_o), 16'hF);
    ta = 80;
    ticks(5);
    chk("R7 hysteresis", 16'(flags_o[5]), 16'h1);
    ta = 78;
    ticks(3);
    chk("R7 cooled", 16'(flags_o[5]), 16'h0);
    ticks(8);
    req_tag = "R3";
    vin = 4000;
    ticks(2);
    vin = 2800;
    ticks(1);
    chk("R3 short glitch ignored", 16'(sysrst_n), 16'h1);
    vin = 1000;
    ticks(4);
    chk("R3 input trip", 16'({flags_o[4], sysrst_n}), 16'b10);
    vin = 2800;
    ticks(16);
    req_tag = "R8";
    iso = 1;
    ticks(2);
    rv[2] = 3400;
    ticks(2);
    chk("R8 only rail 2 off", 16'(shutdown_o), 16'b0100);
    rv[2] = 3000;
    ticks(15);
    req_tag = "R9";
    rv[0] = 3400;
    ticks(2);
    chk("R9 main and derived off", 16'(shutdown_o), 16'b1011);
    rv[0] = 3000;
    ticks(15);
    iso = 0;
    ticks(5);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule